// File: doc/BRIEF.md
# Multistage CIC Decimator with Gain Normalisation

This block reduces the sample rate of a signed sample stream by a fixed integer factor with no multipliers. It is meant to sit at the front of a decimation chain, where the sample rate is highest. The input samples pass through a chain of running-sum (integrator) stages that run at the input rate. A phase counter keeps one sample in every DEC accepted samples, and a chain of differencing (comb) stages with a one-sample delay acts on the kept samples at the output rate.

Each input sample is qualified by a valid strobe. Cycles with the strobe low do not advance any state. A cascade of STAGES sections has a DC gain of DEC^STAGES. The internal words are wide enough to hold that growth, and the output is taken from the top OUT_W bits of the internal word. For a power-of-two DEC this shifts out exactly the processing gain, so a constant input appears unchanged at the output whatever the stage count and decimation factor. The integrators wrap in two's complement on long runs of input, and the wrap cancels in the combs.

Top module: `cic_decimator`

## Requirements
- R1: While rst_n is low at a clock edge, every integrator, comb delay and the decimation phase are cleared, and from the next cycle out_valid is 0 and out_data is 0.
- R2: out_valid is high for exactly one cycle per DEC accepted input samples. It is high in the second cycle after the clock edge that accepts the DEC-th sample of each group, where counting starts at the first accepted sample after reset.
- R3: Output sample m equals floor(S/2^(ACC_W-OUT_W)), truncated to OUT_W bits two's complement. S is the STAGES-fold cascade of DEC-sample running sums of the accepted input stream, evaluated STAGES-1 samples before the last sample of group m, with samples before reset taken as 0. ACC_W is IN_W + STAGES*log2(DEC).
- R4: With a power-of-two DEC, a constant input value x applied long enough to fill the filter gives out_data equal to x, for both x = 2^(IN_W-1)-1 and x = -2^(IN_W-1).
- R5: A cycle with in_valid low has no effect: the decimation phase does not advance, and the output values and the number of accepted samples between pulses are the same as for the gap-free stream.
- R6: Integrator wraparound during runs of full-scale input much longer than 2^ACC_W / 2^IN_W samples leaves every output equal to the value given in R3.
- R7: A reset applied in the middle of a stream discards all earlier history, so the outputs that follow equal those of a filter that starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a decimated sample |
| out_data | output | OUT_W | Signed decimated, gain-normalised sample |

## Verification
A single-sample impulse exposes the exact cascade response and its STAGES-1 sample offset. A filter with the wrong number of stages, the wrong comb delay or a misplaced decimation tap would put the wrong weights on the wrong outputs. Streams with random gaps in the valid strobe catch a phase counter or an integrator that advances on idle cycles, which would shift the output pulses and corrupt the sums. Long full-scale runs of both signs force the integrators to wrap. A design that saturated, or that kept too few bits, would then drift away from the constant input value. A reset in the middle of a group checks that no stale phase or history leaks into the outputs that follow.

// File: rtl/cic_pkg.sv
// Shared sizing helpers for the CIC decimator.
// Assumes the decimation factor is at least 2.
package cic_pkg;

    // Bit growth of a cascade of 'stages' sections decimating by 'dec'.
    function automatic int growth_bits(input int stages, input int dec);
        return stages * $clog2(dec);
    endfunction

endpackage

// File: rtl/cic_integrator_chain.sv
// Cascade of running-sum stages clocked at the input sample rate.
// Each stage adds the registered value of the stage before it, so the chain
// is pipelined. The final stage lags by STAGES-1 accepted samples.
// Sums wrap in two's complement; the comb chain cancels the wrap.
module cic_integrator_chain #(
    parameter int IN_W   = 12,
    parameter int ACC_W  = 21,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IN_W-1:0]  in_data,
    output logic [ACC_W-1:0] sum_out
);
    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] acc_q [STAGES];
    logic [ACC_W-1:0] in_ext;

    // Sign-extend the input sample to the accumulator width.
    assign in_ext = {{EXT_W{in_data[IN_W-1]}}, in_data};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [ACC_W-1:0] addend;
        if (k == 0) begin : g_first
            assign addend = in_ext;
        end else begin : g_next
            assign addend = acc_q[k-1];
        end

        // Accumulate on every accepted sample, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)  acc_q[k] <= '0;
            else if (en) acc_q[k] <= acc_q[k] + addend;
        end
    end

    assign sum_out = acc_q[STAGES-1];
endmodule

// File: rtl/cic_phase_counter.sv
// Counts accepted samples modulo DEC and issues a registered one-cycle tick
// after the edge that accepts the last sample of each group.
// Assumes DEC >= 2.
module cic_phase_counter #(
    parameter int DEC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(DEC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEC - 1);

    logic [CNT_W-1:0] phase_q;
    logic             tick_q;

    // Advance the phase on accepted samples and wrap at the group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= en && (phase_q == LAST);
            if (en) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/cic_comb_chain.sv
// Cascade of differencing stages at the output rate, with a one-sample
// differential delay. The subtractors form one combinational chain, and
// the result is registered once together with its valid flag.
module cic_comb_chain #(
    parameter int ACC_W  = 21,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] in_word,
    output logic [ACC_W-1:0] out_word,
    output logic             out_valid
);
    logic [ACC_W-1:0] link  [STAGES+1];
    logic [ACC_W-1:0] dly_q [STAGES];
    logic [ACC_W-1:0] res_q;
    logic             vld_q;

    assign link[0] = in_word;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        // Difference between this stage's input and its previous input.
        assign link[k+1] = link[k] - dly_q[k];

        // Remember this stage's input for the next decimated sample.
        always_ff @(posedge clk) begin
            if (!rst_n)  dly_q[k] <= '0;
            else if (en) dly_q[k] <= link[k];
        end
    end

    // Capture the chain result and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= en;
            if (en) res_q <= link[STAGES];
        end
    end

    assign out_word  = res_q;
    assign out_valid = vld_q;
endmodule

// File: rtl/cic_output_scaler.sv
// Removes the cascade's processing gain by keeping the top OUT_W bits of
// the internal word. This is an arithmetic shift right by ACC_W-OUT_W
// followed by truncation to OUT_W bits. Assumes OUT_W <= ACC_W.
module cic_output_scaler #(
    parameter int ACC_W = 21,
    parameter int OUT_W = 12
) (
    input  logic [ACC_W-1:0] wide_in,
    output logic [OUT_W-1:0] narrow_out
);
    assign narrow_out = wide_in[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/cic_decimator.sv
// CIC decimator top: integrators at the input rate, a decimation phase
// counter, combs at the output rate and a gain-normalising output slice.
// Assumes DEC is a power of two (needed for exact gain removal), DEC >= 2
// and OUT_W <= IN_W + STAGES*log2(DEC).
module cic_decimator #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 12,
    parameter int STAGES = 3,
    parameter int DEC    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int GROW  = cic_pkg::growth_bits(STAGES, DEC);
    localparam int ACC_W = IN_W + GROW;

    logic [ACC_W-1:0] integ_sum;
    logic [ACC_W-1:0] comb_word;
    logic             dec_tick;

    cic_integrator_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .in_data(in_data), .sum_out(integ_sum)
    );

    cic_phase_counter #(.DEC(DEC)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .tick(dec_tick)
    );

    cic_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
        .clk(clk), .rst_n(rst_n), .en(dec_tick), .in_word(integ_sum),
        .out_word(comb_word), .out_valid(out_valid)
    );

    cic_output_scaler #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scale (
        .wide_in(comb_word), .narrow_out(out_data)
    );
endmodule

// File: rtl/cic_decimator_chk.sv
// Assertion checker for cic_decimator, attached by bind.
// It keeps its own count of accepted samples to predict the output strobe.
module cic_decimator_chk #(
    parameter int DEC   = 8,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    logic [31:0] seen_q;
    logic        hit_d1, hit_d2;

    // Independent group counter and a two-cycle strobe prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            hit_d1 <= 1'b0;
            hit_d2 <= 1'b0;
        end else begin
            hit_d1 <= in_valid && (seen_q == 32'(DEC - 1));
            hit_d2 <= hit_d1;
            if (in_valid) seen_q <= (seen_q == 32'(DEC - 1)) ? '0 : seen_q + 1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    p_strobe_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hit_d2);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_needs_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

bind cic_decimator cic_decimator_chk #(.DEC(DEC), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_cic_decimator.sv
// Self-checking bench: behavioural reference (direct convolution with the
// cascaded boxcar response) compared against the outputs on every clock.
module test_cic_decimator;
    localparam int IN_W = 12, OUT_W = 12, STAGES = 3, DEC = 8;
    localparam int SHIFT = STAGES * $clog2(DEC);
    localparam int HLEN  = STAGES * (DEC - 1) + 1;
    localparam int QMAX  = HLEN + STAGES - 1;
    localparam int MAXV  = (1 << (IN_W - 1)) - 1;
    localparam int MINV  = -(1 << (IN_W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_data;

    always #2 clk = ~clk;

    cic_decimator #(.IN_W(IN_W), .OUT_W(OUT_W), .STAGES(STAGES), .DEC(DEC)) i_cic_decimator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0, failures = 0;
    longint h [HLEN];
    int hist [$];
    longint expq [$];
    int phase = 0;
    bit ev1 = 0, ev2 = 0, rst_was_low = 1;
    string tag = "R3";
    longint last_out = 0;
    bit done = 0;

    task automatic check(input bit ok, input string t, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // Impulse response of the cascade: STAGES-fold convolution of DEC ones.
    task automatic build_h();
        longint tmp [HLEN];
        int len = 1;
        foreach (h[i]) h[i] = 0;
        h[0] = 1;
        for (int s = 0; s < STAGES; s++) begin
            foreach (tmp[i]) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < DEC; j++) tmp[i+j] += h[i];
            len += DEC - 1;
            foreach (h[i]) h[i] = tmp[i];
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next inputs.
    task automatic step(input bit rst, input bit v, input int d);
        bit flag = 0;
        @(negedge clk);
        check(out_valid == ev2, "R2", longint'(out_valid), longint'(ev2));
        if (rst_was_low) begin
            check(!out_valid && out_data == '0, "R1", longint'(out_data), 0);
        end
        if (out_valid) begin
            last_out = longint'($signed(out_data));
            if (expq.size() == 0) check(1'b0, tag, last_out, 0);
            else begin
                longint e = expq.pop_front();
                check(last_out == e, tag, last_out, e);
            end
        end
        ev2 = ev1;
        rst_n = !rst;
        rst_was_low = rst;
        if (rst) begin
            in_valid = 1'b0;
            hist.delete(); expq.delete();
            phase = 0; ev1 = 0; ev2 = 0;
            return;
        end
        in_valid = v;
        in_data = IN_W'(d);
        if (v) begin
            hist.push_front(d);
            if (hist.size() > QMAX) void'(hist.pop_back());
            phase++;
            if (phase == DEC) begin
                longint full = 0;
                phase = 0;
                flag = 1;
                for (int j = 0; j < HLEN; j++)
                    if (STAGES - 1 + j < hist.size()) full += h[j] * hist[STAGES - 1 + j];
                full = full >>> (IN_W + SHIFT - OUT_W);
                expq.push_back(full);
            end
        end
        ev1 = flag;
    endtask

    task automatic flush();
        for (int i = 0; i < 4 * DEC; i++) step(0, 0, 0);
    endtask

    initial begin
        build_h();
        // R1: reset state.
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        // R3: impulse exposes the cascade response and its offset.
        tag = "R3";
        step(0, 1, 1000);
        for (int i = 0; i < 10 * DEC; i++) step(0, 1, 0);
        for (int i = 0; i < 300; i++) step(0, 1, $urandom_range(4095) - 2048);
        // R5: random gaps in the valid strobe.
        tag = "R5";
        for (int i = 0; i < 1500; i++) step(0, ($urandom_range(2) != 0), $urandom_range(4095) - 2048);
        // R4 and R6: long full-scale runs that wrap the integrators.
        tag = "R6";
        for (int i = 0; i < 3000; i++) step(0, 1, MAXV);
        flush();
        check(last_out == MAXV, "R4", last_out, MAXV);
        tag = "R6";
        for (int i = 0; i < 3000; i++) step(0, ($urandom_range(5) != 0), MINV);
        flush();
        check(last_out == MINV, "R4", last_out, MINV);
        // R7: reset in the middle of a group, then restart from zero.
        tag = "R7";
        for (int i = 0; i < DEC + 3; i++) step(0, 1, MAXV);
        step(1, 0, 0); step(1, 0, 0);
        for (int i = 0; i < 400; i++) step(0, 1, (i % 2) ? MAXV : MINV);
        flush();
        check(expq.size() == 0, "R2", longint'(expq.size()), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule